// File: doc/BRIEF.md
# Serial Audio Port Control and Status Register Block

This block is the software-facing register file of a serial audio port. A simple word-addressed register bus reaches eleven registers: a command register, a mode register, a status view with separate write-one clear and set registers, an interrupt mask with separate write-one enable and disable registers, the receive and transmit holding registers and a read-only version word. One-shot command bits become persistent enable states for the receiver, the transmitter and the audio clock generator. These states leave the block as level outputs.

The datapath, the serializers and the clock generator are not part of the block. They appear only as inputs: a received-word strobe with its data, a transmitter-ready level, and per-channel overrun and underrun event vectors for up to eight channels. The block latches each event into a sticky per-channel flag and into a summary flag. It raises a single level interrupt while any masked status source is active. A write to the transmit holding register is handed on to the datapath as a one-cycle load strobe.

Top module: `aud_port_regs`

## Requirements
- R1: Registers sit at byte offsets command 0x00, mode 0x04, status 0x08, status-clear 0x0C, status-set 0x10, irq-enable 0x14, irq-disable 0x18, irq-mask 0x1C, receive holding 0x20, transmit holding 0x24, version 0x28. Reading 0x00, 0x0C, 0x10, 0x14, 0x18 or 0x24 returns zero, and reading 0x28 returns the VERSION parameter.
- R2: A write to 0x00 with bit 0/1 enables/disables the receiver, bit 2/3 the clock generator and bit 4/5 the transmitter. A state persists until the opposite bit is written. If both bits of a pair are written together, disable wins. Status bit 0 shows the receiver state and status bit 4 shows the transmitter state.
- R3: Writing bit 7 of 0x00 clears the enables, every status flag, the irq mask, the mode register and both holding registers by the next cycle. The other bits of that write have no effect.
- R4: A received-word strobe while the receiver is enabled latches the word and sets status bit 1. A read of 0x20 returns the word and clears bit 1 unless a new word arrives in the same cycle. A strobe while the receiver is disabled is ignored.
- R5: An overrun event on channel c while the receiver is enabled sets status bit 8+c and summary bit 2. An underrun event on channel c while the transmitter is enabled sets bit 20+c and summary bit 6. Events on a disabled path are ignored.
- R6: Writing ones to 0x0C clears the matching sticky flags (bits 2, 6, 15:8, 27:20) and leaves bit 1 untouched. An event in the same cycle as its clear keeps the flag set.
- R7: Writing ones to 0x10 sets the matching sticky flags (bits 2, 6, 15:8, 27:20).
- R8: Status bit 5 (transmit ready) equals the transmitter enable ANDed with the transmitter-ready input.
- R9: Writing ones to 0x14 sets mask bits and writing ones to 0x18 clears them. Only bits 1, 2, 5 and 6 can be set. The mask reads at 0x1C.
- R10: irq_o is high exactly when the status word ANDed with the mask is nonzero.
- R11: The mode register at 0x04 holds all 32 written bits and drives mode_o. A write to 0x24 puts the data on tx_word_o and pulses tx_load_o for the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| rx_word_valid_i | input | 1 | Received-word strobe from the datapath |
| rx_word_i | input | 32 | Received word |
| rx_ovr_i | input | NCH | Per-channel receive overrun events |
| tx_ready_i | input | 1 | Transmitter can accept a word |
| tx_udr_i | input | NCH | Per-channel transmit underrun events |
| rx_en_o | output | 1 | Receiver enabled |
| tx_en_o | output | 1 | Transmitter enabled |
| clk_en_o | output | 1 | Clock generator enabled |
| mode_o | output | 32 | Mode register contents |
| tx_word_o | output | 32 | Last word written for transmission |
| tx_load_o | output | 1 | One-cycle load strobe for tx_word_o |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the datapath strobes and event vectors are clean single-cycle levels sampled at the clock edge. They also assume that bus requests carry a settled address and direction for the whole request cycle. The bench changes every input on the falling edge, holds each bus request for exactly one cycle, and pulses events for one cycle at a time. This gives each flag, mask or enable update a single unambiguous edge. Same-cycle collisions, such as an event together with its clear or a new word together with a holding-register read, are produced on purpose by lining up the event pulse with the bus request.

// File: rtl/aud_port_pkg.sv
package aud_port_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned MAX_CH  = 8;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_SCLR = 8'h0C;
  localparam logic [7:0] OFS_SSET = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_IDIS = 8'h18;
  localparam logic [7:0] OFS_IMSK = 8'h1C;
  localparam logic [7:0] OFS_RHLD = 8'h20;
  localparam logic [7:0] OFS_THLD = 8'h24;
  localparam logic [7:0] OFS_VER  = 8'h28;

  // status bit positions
  localparam int unsigned ST_RXEN  = 0;
  localparam int unsigned ST_RXRDY = 1;
  localparam int unsigned ST_RXOR  = 2;
  localparam int unsigned ST_TXEN  = 4;
  localparam int unsigned ST_TXRDY = 5;
  localparam int unsigned ST_TXUR  = 6;
  localparam int unsigned ST_RXCH  = 8;
  localparam int unsigned ST_TXCH  = 20;

  localparam int unsigned CMD_SRST = 7;
  localparam int unsigned N_PAIRS  = 3;  // rx, clk, tx

  localparam logic [REG_W-1:0] IRQ_SRC = 32'h0000_0066;
endpackage

// File: rtl/aud_cmd_enables.sv
module aud_cmd_enables
  import aud_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               srst_i,
  input  logic               cmd_we_i,
  input  logic [2*N_PAIRS-1:0] cmd_i,
  output logic [N_PAIRS-1:0] en_o
);
  logic [N_PAIRS-1:0] en_q;

  // pair k: bit 2k enables, bit 2k+1 disables; disable has priority
  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      en_q[k] <= 1'b0;
      else if (srst_i)                  en_q[k] <= 1'b0;
      else if (cmd_we_i && cmd_i[2*k+1]) en_q[k] <= 1'b0;
      else if (cmd_we_i && cmd_i[2*k])   en_q[k] <= 1'b1;
    end

    a_r2_disable_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_we_i && cmd_i[2*k+1]) |=> !en_o[k]);
    a_r2_state_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmd_we_i && !srst_i) |=> $stable(en_o[k]));
  end

  assign en_o = en_q;

  a_r3_srst_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (en_o == '0));
endmodule

// File: rtl/aud_status_flags.sv
module aud_status_flags
  import aud_port_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             rx_word_valid_i,
  input  logic             rhr_rd_i,
  input  logic [NCH-1:0]   rx_ovr_i,
  input  logic [NCH-1:0]   tx_udr_i,
  input  logic             clr_we_i,
  input  logic             set_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             rxrdy_o,
  output logic             rxor_o,
  output logic             txur_o,
  output logic [NCH-1:0]   rxor_ch_o,
  output logic [NCH-1:0]   txur_ch_o
);
  logic            rxrdy_q, rxor_q, txur_q;
  logic [NCH-1:0]  rx_ev, tx_ev;

  assign rx_ev = rx_en_i ? rx_ovr_i : '0;
  assign tx_ev = tx_en_i ? tx_udr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rxrdy_q <= 1'b0;
    else if (srst_i)                     rxrdy_q <= 1'b0;
    else if (rx_word_valid_i && rx_en_i) rxrdy_q <= 1'b1;
    else if (rhr_rd_i)                   rxrdy_q <= 1'b0;
  end

  // sticky flag: event or set-register beats clear-register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxor_q <= 1'b0;
      txur_q <= 1'b0;
    end else if (srst_i) begin
      rxor_q <= 1'b0;
      txur_q <= 1'b0;
    end else begin
      if ((|rx_ev) || (set_we_i && wdata_i[ST_RXOR])) rxor_q <= 1'b1;
      else if (clr_we_i && wdata_i[ST_RXOR])          rxor_q <= 1'b0;
      if ((|tx_ev) || (set_we_i && wdata_i[ST_TXUR])) txur_q <= 1'b1;
      else if (clr_we_i && wdata_i[ST_TXUR])          txur_q <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rx_f, tx_f;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_f <= 1'b0;
        tx_f <= 1'b0;
      end else if (srst_i) begin
        rx_f <= 1'b0;
        tx_f <= 1'b0;
      end else begin
        if (rx_ev[c] || (set_we_i && wdata_i[ST_RXCH+c])) rx_f <= 1'b1;
        else if (clr_we_i && wdata_i[ST_RXCH+c])          rx_f <= 1'b0;
        if (tx_ev[c] || (set_we_i && wdata_i[ST_TXCH+c])) tx_f <= 1'b1;
        else if (clr_we_i && wdata_i[ST_TXCH+c])          tx_f <= 1'b0;
      end
    end
    assign rxor_ch_o[c] = rx_f;
    assign txur_ch_o[c] = tx_f;

    a_r5_rx_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && rx_en_i && rx_ovr_i[c]) |=> (rxor_ch_o[c] && rxor_o));
    a_r6_event_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && tx_en_i && tx_udr_i[c] && clr_we_i) |=> (txur_ch_o[c] && txur_o));
  end

  assign rxrdy_o = rxrdy_q;
  assign rxor_o  = rxor_q;
  assign txur_o  = txur_q;

  a_r5_rx_off_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !rx_en_i && !set_we_i && !rxor_o) |=> !rxor_o);
  a_r4_read_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && rhr_rd_i && !(rx_word_valid_i && rx_en_i)) |=> !rxrdy_o);
  a_r7_set_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && set_we_i && wdata_i[ST_TXUR]) |=> txur_o);
  a_r3_srst_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!rxrdy_o && !rxor_o && !txur_o && rxor_ch_o == '0 && txur_ch_o == '0));
endmodule

// File: rtl/aud_irq_mask.sv
module aud_irq_mask
  import aud_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             ien_we_i,
  input  logic             idis_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] status_i,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic [REG_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (srst_i)    mask_q <= '0;
    else if (ien_we_i)  mask_q <= mask_q | (wdata_i & IRQ_SRC);
    else if (idis_we_i) mask_q <= mask_q & ~wdata_i;
  end

  assign mask_o = mask_q;
  assign irq_o  = |(status_i & mask_q);

  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && idis_we_i && !ien_we_i) |=> ((mask_o & $past(wdata_i)) == '0));
  a_r9_only_sources: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_we_i |=> ((mask_o & ~IRQ_SRC) == '0));
  a_r3_srst_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (mask_o == '0 && !irq_o));
endmodule

// File: rtl/aud_port_regs.sv
module aud_port_regs
  import aud_port_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NCH     = 8,
  parameter logic [31:0] VERSION = 32'h0001_0203
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              rx_word_valid_i,
  input  logic [31:0]       rx_word_i,
  input  logic [NCH-1:0]    rx_ovr_i,
  input  logic              tx_ready_i,
  input  logic [NCH-1:0]    tx_udr_i,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              clk_en_o,
  output logic [31:0]       mode_o,
  output logic [31:0]       tx_word_o,
  output logic              tx_load_o,
  output logic              irq_o
);
  localparam int unsigned NPAD = MAX_CH - NCH;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr, rd;
  logic cmd_we, srst, mode_we, sclr_we, sset_we, ien_we, idis_we, thld_we, rhr_rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  assign cmd_we  = wr && at(addr_i, OFS_CMD);
  assign srst    = cmd_we && wdata_i[CMD_SRST];
  assign mode_we = wr && at(addr_i, OFS_MODE);
  assign sclr_we = wr && at(addr_i, OFS_SCLR);
  assign sset_we = wr && at(addr_i, OFS_SSET);
  assign ien_we  = wr && at(addr_i, OFS_IEN);
  assign idis_we = wr && at(addr_i, OFS_IDIS);
  assign thld_we = wr && at(addr_i, OFS_THLD);
  assign rhr_rd  = rd && at(addr_i, OFS_RHLD);

  logic [N_PAIRS-1:0] en;
  aud_cmd_enables u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (srst),
    .cmd_we_i (cmd_we && !srst),
    .cmd_i    (wdata_i[2*N_PAIRS-1:0]),
    .en_o     (en)
  );
  assign rx_en_o  = en[0];
  assign clk_en_o = en[1];
  assign tx_en_o  = en[2];

  logic           rxrdy, rxor, txur;
  logic [NCH-1:0] rxor_ch, txur_ch;
  aud_status_flags #(.NCH(NCH)) u_flags (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .srst_i          (srst),
    .rx_en_i         (rx_en_o),
    .tx_en_i         (tx_en_o),
    .rx_word_valid_i (rx_word_valid_i),
    .rhr_rd_i        (rhr_rd),
    .rx_ovr_i        (rx_ovr_i),
    .tx_udr_i        (tx_udr_i),
    .clr_we_i        (sclr_we),
    .set_we_i        (sset_we),
    .wdata_i         (wdata_i),
    .rxrdy_o         (rxrdy),
    .rxor_o          (rxor),
    .txur_o          (txur),
    .rxor_ch_o       (rxor_ch),
    .txur_ch_o       (txur_ch)
  );

  logic [MAX_CH-1:0] rxor_w, txur_w;
  if (NPAD > 0) begin : g_pad
    assign rxor_w = {{NPAD{1'b0}}, rxor_ch};
    assign txur_w = {{NPAD{1'b0}}, txur_ch};
  end else begin : g_nopad
    assign rxor_w = rxor_ch;
    assign txur_w = txur_ch;
  end

  logic [31:0] status;
  assign status = {4'b0, txur_w, 4'b0, rxor_w,
                   1'b0, txur, tx_en_o & tx_ready_i, tx_en_o,
                   1'b0, rxor, rxrdy, rx_en_o};

  logic [31:0] mask;
  aud_irq_mask u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .ien_we_i  (ien_we),
    .idis_we_i (idis_we),
    .wdata_i   (wdata_i),
    .status_i  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  logic [31:0] mode_q, rx_hold_q, tx_word_q;
  logic        tx_load_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      rx_hold_q <= '0;
      tx_word_q <= '0;
      tx_load_q <= 1'b0;
    end else if (srst) begin
      mode_q    <= '0;
      rx_hold_q <= '0;
      tx_word_q <= '0;
      tx_load_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= wdata_i;
      if (rx_word_valid_i && rx_en_o) rx_hold_q <= rx_word_i;
      if (thld_we) tx_word_q <= wdata_i;
      tx_load_q <= thld_we;
    end
  end

  assign mode_o    = mode_q;
  assign tx_word_o = tx_word_q;
  assign tx_load_o = tx_load_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (at(addr_i, OFS_MODE)) rdata_o = mode_q;
      if (at(addr_i, OFS_STAT)) rdata_o = status;
      if (at(addr_i, OFS_IMSK)) rdata_o = mask;
      if (at(addr_i, OFS_RHLD)) rdata_o = rx_hold_q;
      if (at(addr_i, OFS_VER))  rdata_o = VERSION;
    end
  end

  a_r11_thr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thld_we && !srst) |=> (tx_load_o && tx_word_o == $past(wdata_i)));
  a_r11_load_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thld_we |=> !tx_load_o);
  a_r4_word_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst && rx_word_valid_i && rx_en_o) |=> (rx_hold_q == $past(rx_word_i)));
endmodule

// File: tb/aud_port_regs_tb.sv
`timescale 1ns/1ps
module aud_port_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        rxv = 0;
  logic [31:0] rxw = 0;
  logic [7:0]  rxo = 0, txu = 0;
  logic        txr = 0;
  logic        rx_en, tx_en, ck_en, tx_load, irq;
  logic [31:0] mode, tx_word;

  int checks = 0, errors = 0;
  bit done = 0;

  // expected model
  logic e_rx = 0, e_ck = 0, e_tx = 0, e_rdy = 0;
  logic [31:0] e_stk = 0;
  localparam logic [31:0] STK = 32'h0FF0_FF44;
  localparam logic [31:0] VER = 32'h0001_0203;

  always #2.5 clk = ~clk;

  aud_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_word_valid_i(rxv), .rx_word_i(rxw),
    .rx_ovr_i(rxo), .tx_ready_i(txr), .tx_udr_i(txu), .rx_en_o(rx_en),
    .tx_en_o(tx_en), .clk_en_o(ck_en), .mode_o(mode), .tx_word_o(tx_word),
    .tx_load_o(tx_load), .irq_o(irq)
  );

  function automatic logic [31:0] exp_stat();
    return e_stk | {25'b0, 1'b0, e_tx & txr, e_tx, 1'b0, 1'b0, e_rdy, e_rx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(8'h00, {24'b0, c});
    if (c[1]) e_rx = 0; else if (c[0]) e_rx = 1;
    if (c[3]) e_ck = 0; else if (c[2]) e_ck = 1;
    if (c[5]) e_tx = 0; else if (c[4]) e_tx = 1;
  endtask

  task automatic pulse(input logic [7:0] o, input logic [7:0] u);
    @(negedge clk); rxo = o; txu = u;
    @(negedge clk); rxo = 0; txu = 0;
    if (e_rx && o != 0) e_stk = e_stk | (32'(o) << 8) | 32'h4;
    if (e_tx && u != 0) e_stk = e_stk | (32'(u) << 20) | 32'h40;
  endtask

  task automatic word(input logic [31:0] w);
    @(negedge clk); rxv = 1; rxw = w;
    @(negedge clk); rxv = 0;
    if (e_rx) e_rdy = 1;
  endtask

  task automatic stat(input string tag);
    logic [31:0] v;
    rd(8'h08, v);
    chk(tag, v, exp_stat());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, last;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk("R3 reset outputs", {27'b0, rx_en, tx_en, ck_en, tx_load, irq}, 0);
    stat("R1 reset status");
    rd(8'h1C, v); chk("R9 reset mask", v, 0);

    // R1 decode of read-only and write-only addresses
    rd(8'h28, v); chk("R1 version", v, VER);
    foreach (v[i]) ;
    rd(8'h00, v); chk("R1 cmd reads zero", v, 0);
    rd(8'h0C, v); chk("R1 sclr reads zero", v, 0);
    rd(8'h10, v); chk("R1 sset reads zero", v, 0);
    rd(8'h14, v); chk("R1 ien reads zero", v, 0);
    rd(8'h18, v); chk("R1 idis reads zero", v, 0);
    rd(8'h24, v); chk("R1 thld reads zero", v, 0);

    // R2: sweep all command codes without software reset
    for (int c = 0; c < 128; c++) begin
      cmd(8'(c));
      stat("R2 enables in status");
      chk("R2 clk enable", {31'b0, ck_en}, {31'b0, e_ck});
    end

    // R11 mode and transmit holding
    wr(8'h04, 32'hA5C3_0F17);
    rd(8'h04, v); chk("R11 mode read", v, 32'hA5C3_0F17);
    chk("R11 mode_o", mode, 32'hA5C3_0F17);
    wr(8'h24, 32'h1234_5678);
    chk("R11 load pulse", {31'b0, tx_load}, 1);
    chk("R11 tx word", tx_word, 32'h1234_5678);
    @(negedge clk);
    chk("R11 load ends", {31'b0, tx_load}, 0);

    // R5 events ignored while both paths disabled
    cmd(8'h22);
    for (int ch = 0; ch < 8; ch++) pulse(8'(1 << ch), 8'(1 << ch));
    stat("R5 disabled paths ignore events");

    // R4 word ignored when receiver disabled
    word(32'hDEAD_0001);
    stat("R4 word ignored when off");
    rd(8'h20, v); chk("R4 holding unchanged when off", v, 0);

    // R5 per-channel sweep with R6 clear
    cmd(8'h11);
    for (int ch = 0; ch < 8; ch++) begin
      pulse(8'(1 << ch), 0);
      stat("R5 rx overrun channel");
      wr(8'h0C, (32'(1) << (8 + ch)) | 32'h4);
      e_stk = 0;
      stat("R6 clear rx channel");
      pulse(0, 8'(1 << ch));
      stat("R5 tx underrun channel");
      wr(8'h0C, (32'(1) << (20 + ch)) | 32'h40);
      e_stk = 0;
      stat("R6 clear tx channel");
    end

    // R6 event in the same cycle as its clear wins
    @(negedge clk); req = 1; we = 1; addr = 8'h0C; wdata = 32'hFFFF_FFFF; txu = 8'h08;
    @(negedge clk); req = 0; we = 0; txu = 0;
    e_stk = 32'h0080_0040;
    stat("R6 event beats clear");

    // R7 set register, then R6 full clear leaving rxrdy alone
    wr(8'h10, 32'hFFFF_FFFF);
    e_stk = STK;
    stat("R7 set all sticky");
    word(32'hCAFE_0002);
    wr(8'h0C, 32'hFFFF_FFFF);
    e_stk = 0;
    stat("R6 clear keeps rxrdy");

    // R4 read consumes; new word in read cycle keeps ready
    rd(8'h20, v); chk("R4 read data", v, 32'hCAFE_0002);
    e_rdy = 0;
    stat("R4 ready cleared by read");
    word(32'h0000_0033);
    @(negedge clk); req = 1; we = 0; addr = 8'h20; rxv = 1; rxw = 32'h0000_0044;
    #1 last = rdata;
    @(negedge clk); req = 0; rxv = 0;
    chk("R4 read returns older word", last, 32'h0000_0033);
    stat("R4 new word keeps ready");
    rd(8'h20, v); chk("R4 newest word", v, 32'h0000_0044);
    e_rdy = 0;

    // R8 transmit ready
    @(negedge clk); txr = 1;
    stat("R8 txrdy when enabled");
    cmd(8'h20);
    stat("R8 txrdy low when tx off");
    cmd(8'h10);
    @(negedge clk); txr = 0;
    stat("R8 txrdy follows input");

    // R9/R10 sweep: 16 source patterns x 16 mask patterns
    for (int s = 0; s < 16; s++) begin
      wr(8'h0C, 32'hFFFF_FFFF);
      e_stk = 0;
      if (s[1]) begin wr(8'h10, 32'h4); e_stk |= 32'h4; end
      if (s[3]) begin wr(8'h10, 32'h40); e_stk |= 32'h40; end
      if (s[0]) word(32'(s));
      else begin rd(8'h20, v); e_rdy = 0; end
      @(negedge clk); txr = s[2];
      for (int m = 0; m < 16; m++) begin
        logic [31:0] mb;
        mb = {25'b0, m[3], m[2], 2'b0, m[1], m[0], 1'b0};
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h14, mb | 32'hF000_0019);
        rd(8'h1C, v); chk("R9 mask sources only", v, mb);
        chk("R10 irq level", {31'b0, irq}, {31'b0, |(exp_stat() & mb)});
      end
    end

    // R3 software reset with other bits, everything set up first
    wr(8'h10, STK);
    wr(8'h14, 32'h66);
    word(32'h5555_AAAA);
    cmd(8'h04);
    @(negedge clk); txr = 0;
    wr(8'h00, 32'h0000_0095);
    e_rx = 0; e_ck = 0; e_tx = 0; e_rdy = 0; e_stk = 0;
    stat("R3 srst clears status");
    chk("R3 srst enables", {29'b0, rx_en, tx_en, ck_en}, 0);
    rd(8'h1C, v); chk("R3 srst mask", v, 0);
    rd(8'h04, v); chk("R3 srst mode", v, 0);
    rd(8'h20, v); chk("R3 srst holding", v, 0);
    chk("R3 srst irq", {31'b0, irq}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule